// File: doc/BRIEF.md
# Read-Port Behaviour Wrapper for a Simple Dual-Port RAM

This block puts a chosen set of read-port rules around a plain simple-dual-port RAM. The RAM has one write port with per-lane enables and one registered read port, and both run on a single clock. The raw storage makes no promise about what a read returns when a write lands on the same address in the same cycle. The wrapper adds the missing behaviour with explicit logic and leaves the array untouched. That logic covers how the read output resolves an address collision, how the read register is reset, which of reset and enable wins, and the value the register holds from power-up.

The read output is driven by a small source-selection state machine with three states. OUT_POWERUP presents the configured power-up word. OUT_RESET presents the reset word. OUT_READ presents the registered array word, merged with a captured write word on the lanes selected by the collision bypass. Every state follows the same transitions: an effective read reset goes to OUT_RESET, an accepted read goes to OUT_READ, and otherwise the state stays where it is. With the asynchronous reset kind, the reset input forces OUT_RESET at once and needs no clock edge.

Parameters choose the collision mode (read-first, write-first or undefined), whether the read reset is synchronous, asynchronous or absent, and whether reset or enable wins when both are high. Asking for both a synchronous and an asynchronous reset is rejected at elaboration.

Top module: `rdport_wrap`

## Requirements
- R1: A write changes only the byte lanes whose bit in `wr_lanes` is 1. Bit l of `wr_lanes` covers data bits [l*LANE_W +: LANE_W] at `wr_addr`, and the other lanes of that word keep their stored value.
- R2: When a read is accepted at a clock edge (`rd_en` high and no read reset in effect), `rd_data` shows the word stored at `rd_addr` from just after that edge.
- R3: In read-first mode, an accepted read that meets a write to the same address in the same cycle returns the word stored before that write.
- R4: In write-first mode, such a collision returns the incoming write data in every lane the write enables, and the previously stored data in every other lane.
- R5: When `rd_en` is low and no read reset is in effect, `rd_data` keeps its previous value, even if the word it came from is overwritten.
- R6: With a synchronous reset and reset-over-enable priority, `rd_rst` high at an edge loads RESET_VAL into the output, whatever the state of `rd_en`.
- R7: With a synchronous reset and enable-over-reset priority, `rd_rst` loads RESET_VAL only at edges where `rd_en` is also high. With `rd_en` low, the output holds its value.
- R8: With an asynchronous reset, `rd_rst` high forces `rd_data` to RESET_VAL at once, with no clock edge, and keeps it there while `rd_rst` stays high.
- R9: From power-up, `rd_data` shows INIT_VAL until the first accepted read or effective reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_lanes | input | DATA_W/LANE_W | Per-lane write enables |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read enable for the output register |
| rd_rst | input | 1 | Read-register reset (synchronous or asynchronous, set by parameter) |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read result |

## Verification
A read and a write can target the same word in one cycle, and a read enable can arrive together with a read reset. The bench forces both overlaps on purpose: it issues partial-lane and full-lane writes to the address being read, and it raises the reset with the enable both low and high. It also runs a stretch of random traffic over eight addresses, which makes collisions frequent. Three instances in different configurations receive the same stimulus. A behavioural model predicts each output: the merged word for write-first, the old word for read-first, and the reset word or the held value according to priority. In undefined mode the value that follows a collision is not compared.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

    typedef enum logic [1:0] {
        COLL_READ_FIRST,
        COLL_WRITE_FIRST,
        COLL_UNDEFINED
    } coll_mode_e;

    typedef enum logic {
        PRIO_RESET_WINS,
        PRIO_ENABLE_WINS
    } rst_prio_e;

    typedef enum logic [1:0] {
        OUT_POWERUP,
        OUT_RESET,
        OUT_READ
    } out_src_e;

endpackage

// File: rtl/rdport_array.sv
// Raw storage: per-lane write, registered read with enable, no collision promise.
module rdport_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] raw_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_en && wr_lanes[l]) begin
                mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
        if (rd_load) begin
            raw_q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/rdport_bypass.sv
// Collision capture: registers which lanes take the write data and the write word.
module rdport_bypass
    import rdport_pkg::*;
#(
    parameter int         ADDR_W = 6,
    parameter int         DATA_W = 32,
    parameter int         LANE_W = 8,
    parameter coll_mode_e COLL   = COLL_WRITE_FIRST,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] take_mask,
    output logic [DATA_W-1:0] byp_word
);

    generate
        if (COLL == COLL_WRITE_FIRST) begin : g_wf
            logic              same_addr;
            logic [DATA_W-1:0] mask_q;
            logic [DATA_W-1:0] word_q;

            assign same_addr = wr_en && (wr_addr == rd_addr);

            always_ff @(posedge clk) begin
                if (rd_load) begin
                    for (int l = 0; l < LANES; l++) begin
                        mask_q[l*LANE_W +: LANE_W] <= {LANE_W{same_addr && wr_lanes[l]}};
                    end
                    word_q <= wr_data;
                end
            end

            assign take_mask = mask_q;
            assign byp_word  = word_q;
        end else begin : g_nobyp
            assign take_mask = '0;
            assign byp_word  = '0;
        end
    endgenerate

endmodule

// File: rtl/rdport_outctl.sv
// Output source state machine: power-up word, reset word or array word.
module rdport_outctl
    import rdport_pkg::*;
#(
    parameter bit        SYNC_RST  = 1'b1,
    parameter bit        ASYNC_RST = 1'b0,
    parameter rst_prio_e PRIO      = PRIO_RESET_WINS
) (
    input  logic     clk,
    input  logic     rd_en,
    input  logic     rd_rst,
    output logic     rd_load,
    output out_src_e src
);

    localparam bit RST_USED = SYNC_RST || ASYNC_RST;

    out_src_e state_q = OUT_POWERUP;
    out_src_e state_nxt;
    logic     rst_take;

    always_comb begin
        rst_take  = SYNC_RST && rd_rst && ((PRIO == PRIO_RESET_WINS) || rd_en);
        rd_load   = rd_en && !(RST_USED && rd_rst);
        state_nxt = state_q;
        unique case (state_q)
            OUT_POWERUP: begin
                if (rst_take)     state_nxt = OUT_RESET;
                else if (rd_load) state_nxt = OUT_READ;
            end
            OUT_RESET: begin
                if (rd_load)      state_nxt = OUT_READ;
            end
            OUT_READ: begin
                if (rst_take)     state_nxt = OUT_RESET;
            end
            default:              state_nxt = OUT_RESET;
        endcase
    end

    generate
        if (ASYNC_RST) begin : g_async
            always_ff @(posedge clk or posedge rd_rst) begin
                if (rd_rst) state_q <= OUT_RESET;
                else        state_q <= state_nxt;
            end
        end else begin : g_sync
            always_ff @(posedge clk) begin
                state_q <= state_nxt;
            end
        end
    endgenerate

    assign src = state_q;

endmodule

// File: rtl/rdport_wrap.sv
module rdport_wrap
    import rdport_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 32,
    parameter int                LANE_W    = 8,
    parameter coll_mode_e        COLL      = COLL_WRITE_FIRST,
    parameter bit                SYNC_RST  = 1'b1,
    parameter bit                ASYNC_RST = 1'b0,
    parameter rst_prio_e         PRIO      = PRIO_RESET_WINS,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'hA5A5_0F0F,
    parameter logic [DATA_W-1:0] INIT_VAL  = 32'h1234_5678,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    generate
        if (SYNC_RST && ASYNC_RST) begin : g_bad_cfg
            $error("rdport_wrap: synchronous and asynchronous read reset both selected");
        end
    endgenerate

    logic              rd_load;
    out_src_e          src;
    logic [DATA_W-1:0] raw_q;
    logic [DATA_W-1:0] take_mask;
    logic [DATA_W-1:0] byp_word;

    rdport_outctl #(
        .SYNC_RST (SYNC_RST),
        .ASYNC_RST(ASYNC_RST),
        .PRIO     (PRIO)
    ) u_ctl (
        .clk    (clk),
        .rd_en  (rd_en),
        .rd_rst (rd_rst),
        .rd_load(rd_load),
        .src    (src)
    );

    rdport_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LANE_W(LANE_W)
    ) u_arr (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_lanes(wr_lanes),
        .wr_data (wr_data),
        .rd_load (rd_load),
        .rd_addr (rd_addr),
        .raw_q   (raw_q)
    );

    rdport_bypass #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LANE_W(LANE_W),
        .COLL  (COLL)
    ) u_byp (
        .clk      (clk),
        .rd_load  (rd_load),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_lanes (wr_lanes),
        .wr_data  (wr_data),
        .take_mask(take_mask),
        .byp_word (byp_word)
    );

    always_comb begin
        unique case (src)
            OUT_POWERUP: rd_data = INIT_VAL;
            OUT_RESET:   rd_data = RESET_VAL;
            default:     rd_data = (raw_q & ~take_mask) | (byp_word & take_mask);
        endcase
    end

endmodule

// File: rtl/rdport_wrap_chk.sv
module rdport_wrap_chk
    import rdport_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 32,
    parameter int                LANE_W    = 8,
    parameter coll_mode_e        COLL      = COLL_WRITE_FIRST,
    parameter bit                SYNC_RST  = 1'b1,
    parameter bit                ASYNC_RST = 1'b0,
    parameter rst_prio_e         PRIO      = PRIO_RESET_WINS,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'hA5A5_0F0F,
    parameter logic [DATA_W-1:0] INIT_VAL  = 32'h1234_5678,
    localparam int LANES = DATA_W / LANE_W
) (
    input logic              clk,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [LANES-1:0]  wr_lanes,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic              rd_rst,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);

    logic primed = 1'b0;
    logic acted  = 1'b0;

    always_ff @(posedge clk) begin
        primed <= 1'b1;
        if (rd_en || rd_rst) acted <= 1'b1;
    end

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (!primed)
        (!rd_en && !rd_rst) |=> (rd_rst || $stable(rd_data)));

    // R9
    powerup_word_chk: assert property (@(posedge clk) disable iff (!primed)
        (!acted && !rd_rst) |-> (rd_data == INIT_VAL));

    generate
        if (COLL == COLL_WRITE_FIRST) begin : g_wf
            // R4
            wf_collide_chk: assert property (@(posedge clk) disable iff (!primed)
                (rd_en && !rd_rst && wr_en && (wr_addr == rd_addr) && (&wr_lanes))
                |=> (rd_rst || (rd_data == $past(wr_data))));
        end
        if (SYNC_RST && PRIO == PRIO_RESET_WINS) begin : g_rprio
            // R6
            reset_wins_chk: assert property (@(posedge clk) disable iff (!primed)
                rd_rst |=> (rd_data == RESET_VAL));
        end
        if (SYNC_RST && PRIO == PRIO_ENABLE_WINS) begin : g_eprio
            // R7
            enable_gates_reset_chk: assert property (@(posedge clk) disable iff (!primed)
                (rd_rst && rd_en) |=> (rd_data == RESET_VAL));
            // R7
            reset_without_enable_chk: assert property (@(posedge clk) disable iff (!primed)
                (rd_rst && !rd_en) |=> $stable(rd_data));
        end
        if (ASYNC_RST) begin : g_arst
            // R8
            async_reset_level_chk: assert property (@(posedge clk) disable iff (!primed)
                rd_rst |-> (rd_data == RESET_VAL));
        end
    endgenerate

endmodule

bind rdport_wrap rdport_wrap_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LANE_W   (LANE_W),
    .COLL     (COLL),
    .SYNC_RST (SYNC_RST),
    .ASYNC_RST(ASYNC_RST),
    .PRIO     (PRIO),
    .RESET_VAL(RESET_VAL),
    .INIT_VAL (INIT_VAL)
) u_chk (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_lanes(wr_lanes),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_rst  (rd_rst),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/rdport_wrap_tb_top.sv
module rdport_wrap_tb_top;
    import rdport_pkg::*;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int LW = 8;
    localparam int NL = DW / LW;
    localparam logic [DW-1:0] RV = 32'hA5A5_0F0F;
    localparam logic [DW-1:0] IV = 32'h1234_5678;

    logic          clk = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [NL-1:0] wr_lanes = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_rst = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] q_wf, q_rf, q_ud;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    // write-first, synchronous reset, reset wins
    rdport_wrap #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .COLL(COLL_WRITE_FIRST),
        .SYNC_RST(1'b1), .ASYNC_RST(1'b0), .PRIO(PRIO_RESET_WINS),
        .RESET_VAL(RV), .INIT_VAL(IV)) dut_i (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
        .wr_data(wr_data), .rd_en(rd_en), .rd_rst(rd_rst), .rd_addr(rd_addr),
        .rd_data(q_wf));

    // read-first, synchronous reset, enable wins
    rdport_wrap #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .COLL(COLL_READ_FIRST),
        .SYNC_RST(1'b1), .ASYNC_RST(1'b0), .PRIO(PRIO_ENABLE_WINS),
        .RESET_VAL(RV), .INIT_VAL(IV)) dut_rf (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
        .wr_data(wr_data), .rd_en(rd_en), .rd_rst(rd_rst), .rd_addr(rd_addr),
        .rd_data(q_rf));

    // undefined collision, asynchronous reset
    rdport_wrap #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(LW), .COLL(COLL_UNDEFINED),
        .SYNC_RST(1'b0), .ASYNC_RST(1'b1), .PRIO(PRIO_RESET_WINS),
        .RESET_VAL(RV), .INIT_VAL(IV)) dut_ud (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
        .wr_data(wr_data), .rd_en(rd_en), .rd_rst(rd_rst), .rd_addr(rd_addr),
        .rd_data(q_ud));

    // behavioural reference model
    logic [DW-1:0] mem_m [1<<AW];
    logic [DW-1:0] e_wf = IV, e_rf = IV, e_ud = IV;
    bit            k_ud = 1'b1;
    string         t_wf = "R9", t_rf = "R9", t_ud = "R9";
    bit            cmp_on = 1'b0;

    always @(posedge clk) begin
        logic [DW-1:0] old_w, new_w;
        bit hit;
        old_w = mem_m[rd_addr];
        hit   = wr_en && (wr_addr == rd_addr);
        new_w = old_w;
        for (int l = 0; l < NL; l++)
            if (hit && wr_lanes[l]) new_w[l*LW +: LW] = wr_data[l*LW +: LW];
        if (rd_rst) begin
            e_wf = RV; t_wf = "R6";
        end else if (rd_en) begin
            e_wf = new_w; t_wf = hit ? "R4" : "R2";
        end else if (t_wf != "R9") t_wf = "R5";
        if (rd_rst && rd_en) begin
            e_rf = RV; t_rf = "R7";
        end else if (rd_en) begin
            e_rf = old_w; t_rf = hit ? "R3" : "R2";
        end else if (t_rf != "R9") t_rf = rd_rst ? "R7" : "R5";
        if (rd_rst) begin
            e_ud = RV; k_ud = 1'b1; t_ud = "R8";
        end else if (rd_en) begin
            k_ud = !hit; e_ud = old_w; t_ud = "R2";
        end else if (t_ud != "R9") t_ud = "R5";
        for (int l = 0; l < NL; l++)
            if (wr_en && wr_lanes[l]) mem_m[wr_addr][l*LW +: LW] = wr_data[l*LW +: LW];
    end

    task automatic check(input string tag, input string who,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, who, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(t_wf, "write-first", q_wf, e_wf);
            check(t_rf, "read-first", q_rf, e_rf);
            if (k_ud) check(t_ud, "undefined", q_ud, e_ud);
        end
    end

    task automatic step(input logic we, input logic [AW-1:0] wa, input logic [NL-1:0] be,
                        input logic [DW-1:0] wd, input logic re, input logic rr,
                        input logic [AW-1:0] ra);
        @(negedge clk);
        #2;
        wr_en = we; wr_addr = wa; wr_lanes = be; wr_data = wd;
        rd_en = re; rd_rst = rr; rd_addr = ra;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #5;
        // R9: power-up word before any edge
        check("R9", "write-first", q_wf, IV);
        check("R9", "read-first", q_rf, IV);
        check("R9", "undefined", q_ud, IV);
        cmp_on = 1'b1;
        // fill memory with no reads: output stays at power-up word (R9)
        for (int a = 0; a < (1 << AW); a++)
            step(1'b1, AW'(a), '1, (32'h0101_0101 * a) ^ 32'hC0DE_0000, 1'b0, 1'b0, '0);
        // plain reads (R2)
        for (int a = 3; a < 9; a++) step(1'b0, '0, '0, '0, 1'b1, 1'b0, AW'(a));
        // R1: partial-lane write, then read back
        step(1'b1, 6'd5, 4'b0101, 32'hFFFF_FFFF, 1'b0, 1'b0, '0);
        step(1'b0, '0, '0, '0, 1'b1, 1'b0, 6'd5);
        // R3/R4: partial-lane collision, then re-read
        step(1'b1, 6'd9, 4'b0011, 32'hDEAD_BEEF, 1'b1, 1'b0, 6'd9);
        step(1'b0, '0, '0, '0, 1'b1, 1'b0, 6'd9);
        // full-lane collision
        step(1'b1, 6'd10, 4'b1111, 32'h0BAD_F00D, 1'b1, 1'b0, 6'd10);
        // R5: hold while the source word is overwritten
        step(1'b1, 6'd10, 4'b1111, 32'h5555_AAAA, 1'b0, 1'b0, 6'd10);
        step(1'b1, 6'd11, 4'b1111, 32'h7777_8888, 1'b0, 1'b0, 6'd11);
        // R6/R7/R8: reset with enable low
        step(1'b0, '0, '0, '0, 1'b0, 1'b1, 6'd12);
        #2;
        check("R8", "undefined async", q_ud, RV);
        step(1'b0, '0, '0, '0, 1'b1, 1'b0, 6'd12);
        // reset with enable high
        step(1'b0, '0, '0, '0, 1'b1, 1'b1, 6'd13);
        step(1'b0, '0, '0, '0, 1'b1, 1'b0, 6'd14);
        // random traffic over few addresses to provoke collisions
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], AW'(r[3:1]), NL'(r[7:4]), $urandom, r[8] | r[9], (r[12:10] == 3'd0),
                 AW'(r[15:13]));
        end
        step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule